// File: doc/BRIEF.md
# EL2 Invalidate-All Access Gate

This block sits behind the system-instruction decoder. It takes one decoded system instruction per cycle and checks whether it is the outer-shareable "invalidate all EL2 stage-1 translations" operation, either in its plain form or in the form that ignores XS-tagged accesses. When the instruction is one of these two forms, the block weighs it against the current exception level, the EL2 enable, the nested-virtualization and host-extension control bits, and the presence of the features it depends on. It produces exactly one registered outcome: undefined, a trap to EL2, or an invalidate command for the TLB maintenance logic.

The checks form an ordered chain. Feature presence is checked first. The Rt field is checked next. Then the exception level is checked, and after that the nested-virtualization trap and the EL2 enable. The host-extension bit comes last and picks the translation regime. A configuration input, `rt_lax`, decides how a non-all-ones Rt field is handled: the request either becomes undefined or goes ahead as if Rt were all ones.

Top module: `sysop_inval_gate`

## Requirements
- R1: The plain form is recognized when op0=2'b01, op1=3'b100, crn=4'b1000, crm=4'b0001 and op2=3'b000. When it is allowed, it issues a command with `cmd_no_xs`=0.
- R2: The XS-excluding form is recognized when the fields match R1 except crn=4'b1001. When it is allowed, it issues a command with `cmd_no_xs`=1.
- R3: If the XS-excluding form is requested while `has_xs`=0, the outcome is undefined. This check wins over every other check, including the EL1 trap.
- R4: If `has_os_inval`=0, either form is undefined.
- R5: If `cur_el`=0, the outcome is undefined.
- R6: If `cur_el`=1, the outcome is a trap with `trap_ec`=6'h18 when `el2_en`=1 and `nv_bit`=1. In every other EL1 case the outcome is undefined.
- R7: If `cur_el`=2, a command is issued. `cmd_host`=1 (EL2&0 regime) when `e2h_bit`=1, and `cmd_host`=0 (EL2 regime) when `e2h_bit`=0.
- R8: If `cur_el`=3, the outcome is undefined when `el2_en`=0. Otherwise a command is issued with the regime chosen as in R7.
- R9: Every issued command carries `cmd_share`=2'b10 (outer shareable). When no command is issued, `cmd_share`, `cmd_host` and `cmd_no_xs` are 0, and `trap_ec` is 0 unless a trap is signalled.
- R10: If `rt`≠5'b11111, the outcome is undefined when `rt_lax`=0. When `rt_lax`=1, the result is the same as it would be with `rt`=5'b11111.
- R11: The outcome appears one clock after the request. A recognized request with `req_valid`=1 raises exactly one of `res_undef`, `res_trap` and `res_issue`. An unrecognized or idle cycle raises none of them.
- R12: While `rst_n` is low and just after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded instruction present this cycle |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| rt | input | 5 | Transfer register field |
| cur_el | input | 2 | Current exception level 0..3 |
| el2_en | input | 1 | EL2 implemented and enabled in this security state |
| nv_bit | input | 1 | Nested-virtualization control bit |
| e2h_bit | input | 1 | Host-extension control bit |
| has_xs | input | 1 | XS feature present |
| has_os_inval | input | 1 | Outer-shareable invalidation feature present |
| rt_lax | input | 1 | 1: non-all-ones Rt treated as all ones; 0: undefined |
| res_undef | output | 1 | Outcome: undefined |
| res_trap | output | 1 | Outcome: trap to EL2 |
| trap_ec | output | 6 | Exception class of the trap |
| res_issue | output | 1 | Outcome: invalidate command issued |
| cmd_host | output | 1 | Regime: 1 = EL2&0, 0 = EL2 |
| cmd_share | output | 2 | Shareability of the command |
| cmd_no_xs | output | 1 | Attribute filter: 1 = exclude XS, 0 = all |

## Verification
The main collision is an XS-excluding request with `has_xs`=0, made at EL1 while `el2_en`=1 and `nv_bit`=1. That one request meets both the feature-absent condition and the trap condition. The bench drives it on purpose and expects undefined with no trap. A second collision is a bad Rt in strict mode at EL2, where the Rt rule must override the issue. Back-to-back requests from random stimulus, biased toward the two recognized encodings, are compared every cycle against a behavioural model to show that one outcome never leaks into the next cycle.

// File: rtl/sysop_inval_gate.sv
module sysop_inval_gate #(
  parameter logic [5:0] TRAP_EC = 6'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  input  logic [4:0] rt,
  input  logic [1:0] cur_el,
  input  logic       el2_en,
  input  logic       nv_bit,
  input  logic       e2h_bit,
  input  logic       has_xs,
  input  logic       has_os_inval,
  input  logic       rt_lax,
  output logic       res_undef,
  output logic       res_trap,
  output logic [5:0] trap_ec,
  output logic       res_issue,
  output logic       cmd_host,
  output logic [1:0] cmd_share,
  output logic       cmd_no_xs
);
  localparam logic [1:0] SH_OUTER = 2'b10;

  typedef enum logic [1:0] {D_NONE, D_UNDEF, D_TRAP, D_ISSUE} dec_t;

  wire common   = (op0 == 2'b01) && (op1 == 3'b100) && (crm == 4'b0001) && (op2 == 3'b000);
  wire is_plain = common && (crn == 4'b1000);
  wire is_nxs   = common && (crn == 4'b1001);
  wire hit      = req_valid && (is_plain || is_nxs);
  wire rt_ok    = (rt == 5'b11111) || rt_lax;

  dec_t dec;

  always_comb begin
    dec = D_NONE;
    if (hit) begin
      if (is_nxs && !has_xs)   dec = D_UNDEF;
      else if (!has_os_inval)  dec = D_UNDEF;
      else if (!rt_ok)         dec = D_UNDEF;
      else begin
        case (cur_el)
          2'd0:    dec = D_UNDEF;
          2'd1:    dec = (el2_en && nv_bit) ? D_TRAP : D_UNDEF;
          2'd2:    dec = D_ISSUE;
          default: dec = el2_en ? D_ISSUE : D_UNDEF;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_undef <= 1'b0;
      res_trap  <= 1'b0;
      trap_ec   <= '0;
      res_issue <= 1'b0;
      cmd_host  <= 1'b0;
      cmd_share <= '0;
      cmd_no_xs <= 1'b0;
    end else begin
      res_undef <= (dec == D_UNDEF);
      res_trap  <= (dec == D_TRAP);
      trap_ec   <= (dec == D_TRAP) ? TRAP_EC : 6'd0;
      res_issue <= (dec == D_ISSUE);
      cmd_host  <= (dec == D_ISSUE) && e2h_bit;
      cmd_share <= (dec == D_ISSUE) ? SH_OUTER : 2'b00;
      cmd_no_xs <= (dec == D_ISSUE) && is_nxs;
    end
  end

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_undef, res_trap, res_issue}));

  // R11
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (res_undef || res_trap || res_issue));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !(res_undef || res_trap || res_issue));

  // R6
  trap_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap |-> (trap_ec == TRAP_EC));

  // R9
  issue_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_issue |-> (cmd_share == SH_OUTER));

  // R5
  el0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cur_el == 2'd0) |=> res_undef);

  // R3
  xs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_nxs && !has_xs) |=> res_undef);
endmodule

// File: tb/sim_sysop_inval_gate.sv
module sim_sysop_inval_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] op0 = '0;
  logic [2:0] op1 = '0;
  logic [3:0] crn = '0, crm = '0;
  logic [2:0] op2 = '0;
  logic [4:0] rt = '0;
  logic [1:0] cur_el = '0;
  logic el2_en = 0, nv_bit = 0, e2h_bit = 0, has_xs = 0, has_os_inval = 0, rt_lax = 0;
  logic res_undef, res_trap, res_issue, cmd_host, cmd_no_xs;
  logic [5:0] trap_ec;
  logic [1:0] cmd_share;

  always #2 clk = ~clk;

  sysop_inval_gate u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [12:0] exp_v = '0;
  string exp_tag = "R12";

  function automatic logic [12:0] pack_out();
    return {res_undef, res_trap, trap_ec, res_issue, cmd_host, cmd_share, cmd_no_xs};
  endfunction

  task automatic model();
    bit plain, nx;
    int o;
    plain = req_valid && op0 == 1 && op1 == 4 && crn == 8 && crm == 1 && op2 == 0;
    nx    = req_valid && op0 == 1 && op1 == 4 && crn == 9 && crm == 1 && op2 == 0;
    o = 0; exp_tag = "R11 idle";
    if (plain || nx) begin
      if (nx && !has_xs) begin o = 1; exp_tag = "R3"; end
      else if (!has_os_inval) begin o = 1; exp_tag = "R4"; end
      else if (rt != 31 && !rt_lax) begin o = 1; exp_tag = "R10"; end
      else if (cur_el == 0) begin o = 1; exp_tag = "R5"; end
      else if (cur_el == 1) begin o = (el2_en && nv_bit) ? 2 : 1; exp_tag = "R6"; end
      else if (cur_el == 2) begin o = 3; exp_tag = nx ? "R2/R7" : "R1/R7"; end
      else begin o = el2_en ? 3 : 1; exp_tag = "R8"; end
    end
    exp_v = '0;
    if (o == 1) exp_v[12] = 1;
    if (o == 2) begin exp_v[11] = 1; exp_v[10:5] = 6'h18; end
    if (o == 3) begin exp_v[4] = 1; exp_v[3] = e2h_bit; exp_v[2:1] = 2'b10; exp_v[0] = nx; end
  endtask

  task automatic compare();
    checks++;
    if (pack_out() !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", exp_tag, pack_out(), exp_v);
    end
  endtask

  task automatic drive(bit v, bit nx, logic [4:0] r, logic [1:0] el, bit en, bit nv, bit e2, bit xs, bit os, bit lax);
    @(negedge clk);
    compare();
    req_valid = v; op0 = 2'b01; op1 = 3'b100; crn = nx ? 4'b1001 : 4'b1000;
    crm = 4'b0001; op2 = 3'b000; rt = r; cur_el = el; el2_en = en; nv_bit = nv;
    e2h_bit = e2; has_xs = xs; has_os_inval = os; rt_lax = lax;
    model();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    exp_tag = "R12"; exp_v = '0;
    compare();
    rst_n = 1;
    // R1 R7 plain at EL2, both regimes
    drive(1, 0, 31, 2, 1, 0, 0, 1, 1, 0);
    drive(1, 0, 31, 2, 1, 0, 1, 1, 1, 0);
    // R2 nXS at EL2
    drive(1, 1, 31, 2, 1, 0, 1, 1, 1, 0);
    // R3 collision: nXS without XS at EL1 with trap conditions
    drive(1, 1, 31, 1, 1, 1, 0, 0, 1, 0);
    // R4
    drive(1, 0, 31, 2, 1, 0, 0, 1, 0, 0);
    // R5
    drive(1, 0, 31, 0, 1, 1, 0, 1, 1, 0);
    // R6 trap and non-trap
    drive(1, 0, 31, 1, 1, 1, 0, 1, 1, 0);
    drive(1, 0, 31, 1, 0, 1, 0, 1, 1, 0);
    drive(1, 1, 31, 1, 1, 0, 0, 1, 1, 0);
    // R8
    drive(1, 0, 31, 3, 0, 0, 1, 1, 1, 0);
    drive(1, 1, 31, 3, 1, 0, 1, 1, 1, 0);
    // R10 strict and lax
    drive(1, 0, 5, 2, 1, 0, 0, 1, 1, 0);
    drive(1, 0, 5, 2, 1, 0, 1, 1, 1, 1);
    // R11 idle and unrecognized
    drive(0, 0, 31, 2, 1, 0, 0, 1, 1, 0);
    @(negedge clk);
    compare();
    req_valid = 1; op0 = 2'b01; op1 = 3'b100; crn = 4'b1000; crm = 4'b0010; op2 = 0;
    model();
    // random back-to-back
    for (int i = 0; i < 3000; i++) begin
      int p;
      @(negedge clk);
      compare();
      p = $urandom_range(0, 9);
      req_valid = ($urandom_range(0, 7) != 0);
      op0 = (p == 0) ? 2'($urandom) : 2'b01;
      op1 = (p == 1) ? 3'($urandom) : 3'b100;
      crn = (p == 2) ? 4'($urandom) : ($urandom_range(0, 1) ? 4'b1001 : 4'b1000);
      crm = (p == 3) ? 4'($urandom) : 4'b0001;
      op2 = (p == 4) ? 3'($urandom) : 3'b000;
      rt = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b11111;
      cur_el = 2'($urandom);
      el2_en = 1'($urandom); nv_bit = 1'($urandom); e2h_bit = 1'($urandom);
      has_xs = ($urandom_range(0, 3) != 0); has_os_inval = ($urandom_range(0, 5) != 0);
      rt_lax = 1'($urandom);
      model();
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule